// File: doc/BRIEF.md
# System Control Coprocessor Register Block

This block is the system-control coprocessor attached to a 32-bit RISC core. The core presents one coprocessor move per cycle on a request port. The port carries the full instruction word, the value of the source register, a register index and a 10-bit operation code. The block decodes the move, and the instruction's direction bit selects the access:

- A move-from returns the selected register on the read-data output in the same cycle.
- A move-to updates the selected register on the next rising clock edge.

Six registers are visible. Two are read-only and set by parameters: CPU identification and cache type. Four are writable: system control, page-table base, fault status and fault address.

Two register indices accept commands instead of holding data. Writes to the cache-operation index raise a one-cycle strobe for each recognised maintenance command. Writes to the TLB-operation index raise a whole-TLB flush strobe. The cache and TLB hardware that act on these strobes sit outside this block.

A word that does not belong to the coprocessor raises an illegal-instruction flag. A write that matches no known register or command raises an unrecognised-access flag. Neither changes any state.

Top module: `scp_ctrl`

## Requirements
- R1: A request is decoded only when instruction bits [31:25] equal 7'b1110000. Any other valid word pulses `bad_insn_o` in the cycle after the request. It changes no register, returns zero on `rd_data_o` and raises no strobe.
- R2: Instruction bit 24 selects the direction. A value of 1 is a read of the selected register onto `rd_data_o`. A value of 0 is a write of `wr_data_i` into the selected register.
- R3: Indices 1, 2, 3 and 4 (system control, page-table base, fault status, fault address) are read and written only with operation code 0. A write takes effect at the clock edge that accepts the request. A read returns the value combinationally in the request cycle.
- R4: Index 0 is read-only. Operation code 0 returns parameter CPU_ID and operation code 1 returns parameter CACHE_TYPE. A write to index 0 is unrecognised (R8).
- R5: A write to index 5 pulses one bit of `cache_strb_o` in the cycle after the request and changes no register. The mapping from operation code to bit is:
  - 12: bit 0, invalidate all data cache
  - 20: bit 1, invalidate all instruction cache
  - 28: bit 2, invalidate both caches
  - 10: bit 3, clean all data cache
  - 14: bit 4, flush all data cache
  - 11: bit 5, clean one data line
  - 13: bit 6, invalidate one data line
  - 15: bit 7, flush one data line
- R6: A write to index 6 with an operation code from 2 to 6 inclusive pulses `tlb_flush_o` in the cycle after the request.
- R7: A read of any index and operation code pair not listed in R3 or R4 returns zero on `rd_data_o` and raises no flag.
- R8: A write of any index and operation code pair not listed in R3, R5 or R6 pulses `bad_access_o` in the cycle after the request and leaves every register unchanged.
- R9: After synchronous active-high reset, the four writable registers read zero and all strobes and flags are low.
- R10: Strobes and flags are high for exactly one cycle per request. They are never raised by reads, and never raised in a cycle after `req_valid_i` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| insn_i | input | 32 | Instruction word |
| wr_data_i | input | 32 | Source register value for writes |
| reg_idx_i | input | IDX_W | Coprocessor register index |
| op_code_i | input | OP_W | Operation code |
| rd_data_o | output | 32 | Read data, same cycle |
| cache_strb_o | output | 8 | Cache maintenance strobes |
| tlb_flush_o | output | 1 | Whole-TLB flush strobe |
| bad_insn_o | output | 1 | Word is not a coprocessor move |
| bad_access_o | output | 1 | Unrecognised write |

## Verification
The bench walks every cache operation code and checks that exactly its own strobe bit fires. A decoder with swapped codes would light the wrong bit. The bench probes the TLB range at both ends and just outside them (codes 1, 2, 6 and 7), which catches an off-by-one bound. The bench also writes registers with a nonzero operation code, writes the read-only index and writes with a foreign word, then reads the registers back. A design that ignored the operation code or the word check would show the new value there. Reads of command indices and of unknown pairs must return zero without a strobe, which exposes strobes that are not gated by direction.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_CACHE = 8;
  localparam int unsigned CODE_W  = 10;
  localparam logic [6:0]  MATCH_HI = 7'b1110000;
  localparam int unsigned IDX_CACHE = 5;
  localparam int unsigned IDX_TLB   = 6;
  localparam int unsigned TLB_LO    = 2;
  localparam int unsigned TLB_HI    = 6;

  // operation code for each strobe bit, bit 0 first
  function automatic logic [CODE_W-1:0] cache_code(input int unsigned bit_i);
    case (bit_i)
      0: cache_code = 10'd12;
      1: cache_code = 10'd20;
      2: cache_code = 10'd28;
      3: cache_code = 10'd10;
      4: cache_code = 10'd14;
      5: cache_code = 10'd11;
      6: cache_code = 10'd13;
      default: cache_code = 10'd15;
    endcase
  endfunction
endpackage

// File: rtl/scp_decode.sv
module scp_decode import scp_pkg::*; #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OP_W  = 10,
  parameter int unsigned NREG  = 4
) (
  input  logic                 valid_i,
  input  logic [31:0]          insn_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [OP_W-1:0]      op_i,
  output logic                 rd_en_o,
  output logic [NREG:1]        wr_sel_o,
  output logic [N_CACHE-1:0]   cache_hit_o,
  output logic                 tlb_hit_o,
  output logic                 bad_insn_o,
  output logic                 bad_wr_o
);
  logic ours, is_wr, op_zero, known_wr;

  assign ours    = (insn_i[31:25] == MATCH_HI);
  assign op_zero = (op_i == '0);
  assign is_wr   = valid_i && ours && !insn_i[24];
  assign rd_en_o = valid_i && ours && insn_i[24];
  assign bad_insn_o = valid_i && !ours;

  genvar g;
  generate
    for (g = 1; g <= NREG; g++) begin : g_wsel
      assign wr_sel_o[g] = is_wr && op_zero && (idx_i == IDX_W'(g));
    end
    for (g = 0; g < N_CACHE; g++) begin : g_cache
      assign cache_hit_o[g] = is_wr && (idx_i == IDX_W'(IDX_CACHE)) &&
                              (op_i == OP_W'(cache_code(g)));
    end
  endgenerate

  assign tlb_hit_o = is_wr && (idx_i == IDX_W'(IDX_TLB)) &&
                     (op_i >= OP_W'(TLB_LO)) && (op_i <= OP_W'(TLB_HI));
  assign known_wr  = (|wr_sel_o) || (|cache_hit_o) || tlb_hit_o;
  assign bad_wr_o  = is_wr && !known_wr;
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile import scp_pkg::*; #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OP_W  = 10,
  parameter int unsigned NREG  = 4,
  parameter logic [DATA_W-1:0] CPU_ID     = 32'h0,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG:1]      wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] regs [1:NREG];

  genvar g;
  generate
    for (g = 1; g <= NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)              regs[g] <= '0;
        else if (wr_sel_i[g]) regs[g] <= wr_data_i;
      end
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (idx_i == '0) begin
        if (op_i == OP_W'(0))      rd_data_o = CPU_ID;
        else if (op_i == OP_W'(1)) rd_data_o = CACHE_TYPE;
      end else if (op_i == '0) begin
        for (int i = 1; i <= NREG; i++)
          if (idx_i == IDX_W'(i)) rd_data_o = regs[i];
      end
    end
  end
endmodule

// File: rtl/scp_strobe.sv
module scp_strobe import scp_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CACHE-1:0] cache_hit_i,
  input  logic               tlb_hit_i,
  input  logic               bad_insn_i,
  input  logic               bad_wr_i,
  output logic [N_CACHE-1:0] cache_strb_o,
  output logic               tlb_flush_o,
  output logic               bad_insn_o,
  output logic               bad_access_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_strb_o <= '0;
      tlb_flush_o  <= 1'b0;
      bad_insn_o   <= 1'b0;
      bad_access_o <= 1'b0;
    end else begin
      cache_strb_o <= cache_hit_i;
      tlb_flush_o  <= tlb_hit_i;
      bad_insn_o   <= bad_insn_i;
      bad_access_o <= bad_wr_i;
    end
  end
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl import scp_pkg::*; #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OP_W  = 10,
  parameter logic [31:0] CPU_ID     = 32'h4D11_0863,
  parameter logic [31:0] CACHE_TYPE = 32'h0D17_2196
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid_i,
  input  logic [31:0]        insn_i,
  input  logic [31:0]        wr_data_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [OP_W-1:0]    op_code_i,
  output logic [31:0]        rd_data_o,
  output logic [N_CACHE-1:0] cache_strb_o,
  output logic               tlb_flush_o,
  output logic               bad_insn_o,
  output logic               bad_access_o
);
  localparam int unsigned NREG = 4;

  logic               rd_en, tlb_hit, bad_insn, bad_wr;
  logic [NREG:1]      wr_sel;
  logic [N_CACHE-1:0] cache_hit;

  scp_decode #(.IDX_W(IDX_W), .OP_W(OP_W), .NREG(NREG)) u_dec (
    .valid_i(req_valid_i), .insn_i(insn_i), .idx_i(reg_idx_i), .op_i(op_code_i),
    .rd_en_o(rd_en), .wr_sel_o(wr_sel), .cache_hit_o(cache_hit),
    .tlb_hit_o(tlb_hit), .bad_insn_o(bad_insn), .bad_wr_o(bad_wr)
  );

  scp_regfile #(.IDX_W(IDX_W), .OP_W(OP_W), .NREG(NREG),
                .CPU_ID(CPU_ID), .CACHE_TYPE(CACHE_TYPE)) u_rf (
    .clk(clk), .rst(rst), .wr_sel_i(wr_sel), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en), .idx_i(reg_idx_i), .op_i(op_code_i), .rd_data_o(rd_data_o)
  );

  scp_strobe u_stb (
    .clk(clk), .rst(rst), .cache_hit_i(cache_hit), .tlb_hit_i(tlb_hit),
    .bad_insn_i(bad_insn), .bad_wr_i(bad_wr), .cache_strb_o(cache_strb_o),
    .tlb_flush_o(tlb_flush_o), .bad_insn_o(bad_insn_o), .bad_access_o(bad_access_o)
  );
endmodule

// File: rtl/scp_ctrl_chk.sv
module scp_ctrl_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OP_W  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid_i,
  input logic [31:0]      insn_i,
  input logic [IDX_W-1:0] reg_idx_i,
  input logic [OP_W-1:0]  op_code_i,
  input logic [31:0]      rd_data_o,
  input logic [7:0]       cache_strb_o,
  input logic             tlb_flush_o,
  input logic             bad_insn_o,
  input logic             bad_access_o
);
  logic ours;
  assign ours = (insn_i[31:25] == 7'b1110000);

  AST_BAD_INSN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !ours) |=> (bad_insn_o && cache_strb_o == '0 && !tlb_flush_o)); // R1
  AST_BAD_INSN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !ours) |-> (rd_data_o == '0)); // R1
  AST_CACHE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cache_strb_o)); // R5
  AST_TLB_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && ours && !insn_i[24] && reg_idx_i == IDX_W'(6) &&
     op_code_i >= OP_W'(2) && op_code_i <= OP_W'(6)) |=> tlb_flush_o); // R6
  AST_NO_STRB_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && insn_i[24]) |=> (cache_strb_o == '0 && !tlb_flush_o && !bad_access_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (cache_strb_o == '0 && !tlb_flush_o && !bad_access_o && !bad_insn_o)); // R10
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && ours && insn_i[24] && reg_idx_i > IDX_W'(4)) |-> (rd_data_o == '0)); // R7
endmodule

bind scp_ctrl scp_ctrl_chk #(.IDX_W(IDX_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .insn_i(insn_i),
  .reg_idx_i(reg_idx_i), .op_code_i(op_code_i), .rd_data_o(rd_data_o),
  .cache_strb_o(cache_strb_o), .tlb_flush_o(tlb_flush_o),
  .bad_insn_o(bad_insn_o), .bad_access_o(bad_access_o)
);

// File: tb/scp_ctrl_tb_top.sv
module scp_ctrl_tb_top;
  localparam logic [31:0] P_ID = 32'h4D11_0863;
  localparam logic [31:0] P_CT = 32'h0D17_2196;
  localparam logic [31:0] W_RD = 32'hE100_0000;
  localparam logic [31:0] W_WR = 32'hE000_0000;
  localparam logic [31:0] W_BAD = 32'hF000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid_i = 1'b0;
  logic [31:0] insn_i = '0, wr_data_i = '0;
  logic [3:0]  reg_idx_i = '0;
  logic [9:0]  op_code_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  cache_strb_o;
  logic tlb_flush_o, bad_insn_o, bad_access_o;
  int n_vec = 0, n_bad = 0;

  logic [31:0] s_rd;
  logic [7:0]  s_strb;
  logic        s_tlb, s_bi, s_ba;

  always #4 clk = ~clk;

  scp_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request cycle; samples read data before the edge, pulses after it
  task automatic issue(input logic [31:0] w, input logic [3:0] idx,
                       input logic [9:0] op, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; insn_i = w; reg_idx_i = idx; op_code_i = op; wr_data_i = d;
    #1 s_rd = rd_data_o;
    @(posedge clk); #1;
    s_strb = cache_strb_o; s_tlb = tlb_flush_o; s_bi = bad_insn_o; s_ba = bad_access_o;
    @(negedge clk);
    req_valid_i = 1'b0; insn_i = '0; wr_data_i = '0;
  endtask

  function automatic logic [31:0] rd_of(input logic [3:0] idx, input logic [9:0] op);
    return 32'h0;
  endfunction

  task automatic read_chk(input string req, input logic [3:0] idx,
                          input logic [9:0] op, input logic [31:0] exp);
    issue(W_RD, idx, op, 32'h0);
    chk(req, s_rd, exp);
    chk({req, " no strobe on read"}, {22'h0, s_strb, s_tlb, s_ba}, 32'h0);
  endtask

  task automatic t_reset();
    for (int i = 1; i <= 4; i++) read_chk("R9 reg reset", 4'(i), 10'd0, 32'h0);
    chk("R9 outputs reset", {28'h0, cache_strb_o == 0, tlb_flush_o, bad_insn_o, bad_access_o}, 32'h8);
  endtask

  task automatic t_regs();
    for (int i = 1; i <= 4; i++) begin
      issue(W_WR, 4'(i), 10'd0, 32'hA500_0000 + i);
      chk("R3 write no flag", {31'h0, s_ba}, 32'h0);
    end
    for (int i = 1; i <= 4; i++) read_chk("R3 readback", 4'(i), 10'd0, 32'hA500_0000 + i);
  endtask

  task automatic t_idx0();
    read_chk("R4 cpu id", 4'd0, 10'd0, P_ID);
    read_chk("R4 cache type", 4'd0, 10'd1, P_CT);
    read_chk("R7 idx0 op2", 4'd0, 10'd2, 32'h0);
    issue(W_WR, 4'd0, 10'd0, 32'hFFFF_FFFF);
    chk("R4 write idx0 flagged", {31'h0, s_ba}, 32'h1);
    read_chk("R4 idx0 unchanged", 4'd0, 10'd0, P_ID);
  endtask

  task automatic t_unrec();
    issue(W_WR, 4'd2, 10'd1, 32'hDEAD_0001);
    chk("R8 nonzero op write flagged", {31'h0, s_ba}, 32'h1);
    read_chk("R8 reg unchanged", 4'd2, 10'd0, 32'hA500_0002);
    read_chk("R7 nonzero op read", 4'd2, 10'd1, 32'h0);
    read_chk("R7 read cache idx", 4'd5, 10'd12, 32'h0);
    read_chk("R7 read idx9", 4'd9, 10'd0, 32'h0);
    issue(W_WR, 4'd9, 10'd0, 32'h1);
    chk("R8 idx9 write", {31'h0, s_ba}, 32'h1);
    issue(W_WR, 4'd5, 10'd16, 32'h0);
    chk("R8 unknown cache op", {23'h0, s_strb, s_ba}, 32'h1);
    issue(W_WR, 4'd3, 10'd0, 32'h1);
    @(posedge clk); #1;
    chk("R10 flag one cycle", {30'h0, bad_access_o, cache_strb_o != 0}, 32'h0);
  endtask

  task automatic t_cache();
    logic [9:0] codes [8] = '{10'd12, 10'd20, 10'd28, 10'd10, 10'd14, 10'd11, 10'd13, 10'd15};
    for (int b = 0; b < 8; b++) begin
      issue(W_WR, 4'd5, codes[b], 32'h0);
      chk("R5 cache strobe bit", {23'h0, s_strb, s_ba}, {23'h0, 8'(1 << b), 1'b0});
      @(posedge clk); #1;
      chk("R10 strobe one cycle", {24'h0, cache_strb_o}, 32'h0);
    end
    read_chk("R5 regs untouched", 4'd1, 10'd0, 32'hA500_0001);
  endtask

  task automatic t_tlb();
    for (int op = 1; op <= 7; op++) begin
      issue(W_WR, 4'd6, 10'(op), 32'h0);
      chk("R6 tlb flush", {30'h0, s_tlb, s_ba}, (op >= 2 && op <= 6) ? 32'h2 : 32'h1);
    end
    @(posedge clk); #1;
    chk("R10 tlb one cycle", {31'h0, tlb_flush_o}, 32'h0);
  endtask

  task automatic t_foreign();
    issue(W_BAD, 4'd1, 10'd0, 32'h1234_5678);
    chk("R1 foreign write flag", {22'h0, s_strb, s_bi, s_ba}, 32'h2);
    issue(W_BAD | 32'h0100_0000, 4'd0, 10'd0, 32'h0);
    chk("R1 foreign read zero", s_rd, 32'h0);
    issue(W_BAD, 4'd5, 10'd12, 32'h0);
    chk("R1 foreign no strobe", {23'h0, s_strb, s_bi}, 32'h1);
    read_chk("R1 reg unchanged", 4'd1, 10'd0, 32'hA500_0001);
  endtask

  task automatic t_dir();
    issue(W_RD, 4'd4, 10'd0, 32'h5555_AAAA);
    chk("R2 read does not write", s_rd, 32'hA500_0004);
    read_chk("R2 reg unchanged", 4'd4, 10'd0, 32'hA500_0004);
    issue(W_WR, 4'd4, 10'd0, 32'h5555_AAAA);
    chk("R2 write no read data", s_rd, 32'h0);
    read_chk("R2 write took", 4'd4, 10'd0, 32'h5555_AAAA);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset(); t_regs(); t_idx0(); t_unrec(); t_cache(); t_tlb(); t_foreign(); t_dir();
      end
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule